// File: doc/BRIEF.md
# Dual-Port Pipelined Byte-Lane RAM

This block is a synchronous memory with two symmetric access ports, called left and right. Both ports can reach every word in the same cycle. Each word is split into byte lanes of nine bits. A write changes only the lanes whose enables are asserted. Reads are pipelined. The address and controls are captured on one rising edge, and the data and per-lane valid flags are presented after the next rising edge.

A port performs an access only when its two chip enables agree: the active-low enable is low and the active-high enable is high. An output enable gates the valid flags combinationally and does not disturb the pipeline. The read and write data buses are separate, which replaces a bidirectional pad. Both ports share one clock, so collisions between them have a defined result. The depth is a parameter. The default depth is kept small, and setting `ADDR_W` to 15 gives 32K words.

Top module: `dpr_bytelane_ram`

## Requirements
- R1: A port accesses memory only when `*_ce_lo_n` is 0 and `*_ce_hi` is 1. With any other combination, nothing is written and no valid flag rises.
- R2: `*_rd_wr_n` at 1 selects a read and at 0 selects a write. A write cycle never raises a valid flag.
- R3: Lane 1 (`*_bsel_n[1]`, active low) covers data bits 17..9. Lane 0 (`*_bsel_n[0]`, active low) covers bits 8..0. A write with one lane enabled leaves the other lane's stored bits unchanged.
- R4: When both lane enables are 1, the cycle is an idle cycle. Nothing is written and both valid flags stay 0.
- R5: Controls are sampled on rising edge N. Read data and valid flags appear right after rising edge N+1, and not earlier.
- R6: Valid bit k of `*_rvld` is 1 only when lane k was enabled on a selected read.
- R7: `*_oe_n` at 1 forces `*_rvld` to 0 at once, without a clock edge. `*_rdata` and the registered state are unaffected. When `*_oe_n` returns to 0, the flags come back.
- R8: The two ports access independent or equal addresses in the same cycle without interfering.
- R9: When both ports write the same word in the same cycle, the right port's value wins on each lane that both ports enable. Lanes enabled by only one port take that port's data.
- R10: A read on one port of a word that the other port writes in the same cycle returns the value from before that write.
- R11: After reset, both ports' valid flags are 0.
- R12: `*_rdata` keeps its last value through every cycle that has no selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_ce_lo_n | input | 1 | Left chip enable, active low |
| l_ce_hi | input | 1 | Left chip enable, active high |
| l_rd_wr_n | input | 1 | Left read (1) or write (0) |
| l_bsel_n | input | 2 | Left lane enables, active low, bit 1 = bits 17..9 |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data |
| l_rvld | output | 2 | Left per-lane read valid |
| r_ce_lo_n | input | 1 | Right chip enable, active low |
| r_ce_hi | input | 1 | Right chip enable, active high |
| r_rd_wr_n | input | 1 | Right read (1) or write (0) |
| r_bsel_n | input | 2 | Right lane enables, active low, bit 1 = bits 17..9 |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data |
| r_rvld | output | 2 | Right per-lane read valid |

## Verification
The bench aims at the collision cases first. Two writes to the same word with overlapping lanes must merge per lane with the right port winning; a design that let the left port win, or let one port's write mask the other, would store a mixed or wrong word. A read racing a write from the other port must return the old value; a write-first array would return the new one. Single-lane writes, both-lanes-disabled cycles and both wrong chip-enable combinations are each followed by full reads, so a lane-mapping swap or a polarity error shows up as corrupted neighbour bits. Reads timed against the output enable and against idle cycles catch an off-by-one pipeline, a clocked output gate, and read data that drifts while no read is in flight.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } dpr_op_e;

endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_lo_n,
  input  logic                      ce_hi,
  input  logic                      rd_wr_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [ADDR_W-1:0]         acc_addr,
  output logic [LANES*LANE_W-1:0]   acc_wdata,
  output logic [LANES-1:0]          acc_wmask,
  output logic                      acc_rd,
  input  logic [LANES*LANE_W-1:0]   rdata,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic [LANES-1:0]          dout_vld
);

  localparam int DATA_W = LANES * LANE_W;

  dpr_op_e             op_d, op_q;
  logic [LANES-1:0]    lanes_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    vld_d, vld_q;
  logic                sel;

  // next-state: decode the request
  always_comb begin
    sel = !ce_lo_n && ce_hi;
    if (!sel || (&bsel_n)) op_d = OP_IDLE;
    else if (rd_wr_n)      op_d = OP_READ;
    else                   op_d = OP_WRITE;
    vld_d = (op_q == OP_READ) ? lanes_q : '0;
  end

  // control registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      vld_q <= '0;
    end else begin
      op_q  <= op_d;
      vld_q <= vld_d;
    end
  end

  // datapath input registers, no reset needed
  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
    lanes_q <= ~bsel_n;
  end

  assign acc_addr  = addr_q;
  assign acc_wdata = wdata_q;
  assign acc_rd    = (op_q == OP_READ);
  assign acc_wmask = (op_q == OP_WRITE) ? lanes_q : '0;
  assign dout      = rdata;
  assign dout_vld  = vld_q & ~{LANES{oe_n}};

  // R1
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_n || !ce_hi) |=> (op_q == OP_IDLE));

  // R1
  idle_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE) |=> (vld_q == '0));

  // R2
  write_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |=> (vld_q == '0));

  // R6
  vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld_q) |-> $past(op_q == OP_READ));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rdata));

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         l_addr,
  input  logic [LANES*LANE_W-1:0]   l_wdata,
  input  logic [LANES-1:0]          l_wmask,
  input  logic                      l_rd,
  output logic [LANES*LANE_W-1:0]   l_rdata,
  input  logic [ADDR_W-1:0]         r_addr,
  input  logic [LANES*LANE_W-1:0]   r_wdata,
  input  logic [LANES-1:0]          r_wmask,
  input  logic                      r_rd,
  output logic [LANES*LANE_W-1:0]   r_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic same_word;
  assign same_word = (l_addr == r_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] l_q, r_q;
    logic              l_we, r_we;

    // right port owns a lane when both target the same word
    always_comb begin
      r_we = r_wmask[g];
      l_we = l_wmask[g] && !(r_we && same_word);
    end

    // reads sample before this edge's writes land: old data on collision
    always_ff @(posedge clk) begin
      if (l_we) mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
      if (r_we) mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
      if (l_rd) l_q <= mem[l_addr];
      if (r_rd) r_q <= mem[r_addr];
    end

    assign l_rdata[g*LANE_W +: LANE_W] = l_q;
    assign r_rdata[g*LANE_W +: LANE_W] = r_q;

    // R9
    lane_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_we && r_we && same_word));
  end

endmodule

// File: rtl/dpr_bytelane_ram.sv
module dpr_bytelane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      l_ce_lo_n,
  input  logic                      l_ce_hi,
  input  logic                      l_rd_wr_n,
  input  logic [LANES-1:0]          l_bsel_n,
  input  logic                      l_oe_n,
  input  logic [ADDR_W-1:0]         l_addr,
  input  logic [LANES*LANE_W-1:0]   l_wdata,
  output logic [LANES*LANE_W-1:0]   l_rdata,
  output logic [LANES-1:0]          l_rvld,
  input  logic                      r_ce_lo_n,
  input  logic                      r_ce_hi,
  input  logic                      r_rd_wr_n,
  input  logic [LANES-1:0]          r_bsel_n,
  input  logic                      r_oe_n,
  input  logic [ADDR_W-1:0]         r_addr,
  input  logic [LANES*LANE_W-1:0]   r_wdata,
  output logic [LANES*LANE_W-1:0]   r_rdata,
  output logic [LANES-1:0]          r_rvld
);

  localparam int DATA_W = LANES * LANE_W;

  logic               rst_n_s;
  logic [ADDR_W-1:0]  la, ra;
  logic [DATA_W-1:0]  lw, rw, lr, rr;
  logic [LANES-1:0]   lm, rm;
  logic               lrd, rrd;

  dpr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_left (
    .clk(clk), .rst_n(rst_n_s),
    .ce_lo_n(l_ce_lo_n), .ce_hi(l_ce_hi), .rd_wr_n(l_rd_wr_n),
    .bsel_n(l_bsel_n), .oe_n(l_oe_n), .addr(l_addr), .wdata(l_wdata),
    .acc_addr(la), .acc_wdata(lw), .acc_wmask(lm), .acc_rd(lrd),
    .rdata(lr), .dout(l_rdata), .dout_vld(l_rvld)
  );

  dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_right (
    .clk(clk), .rst_n(rst_n_s),
    .ce_lo_n(r_ce_lo_n), .ce_hi(r_ce_hi), .rd_wr_n(r_rd_wr_n),
    .bsel_n(r_bsel_n), .oe_n(r_oe_n), .addr(r_addr), .wdata(r_wdata),
    .acc_addr(ra), .acc_wdata(rw), .acc_wmask(rm), .acc_rd(rrd),
    .rdata(rr), .dout(r_rdata), .dout_vld(r_rvld)
  );

  dpr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n_s),
    .l_addr(la), .l_wdata(lw), .l_wmask(lm), .l_rd(lrd), .l_rdata(lr),
    .r_addr(ra), .r_wdata(rw), .r_wmask(rm), .r_rd(rrd), .r_rdata(rr)
  );

  // R11
  reset_vld_chk: assert property (@(posedge clk)
    !rst_n_s |=> (l_rvld == '0 && r_rvld == '0));

endmodule

// File: tb/tb_dpr_bytelane_ram.sv
module tb_dpr_bytelane_ram;

  localparam int AW = 10;

  typedef struct packed {
    logic        ce_lo_n;
    logic        ce_hi;
    logic        rd;
    logic [1:0]  bsel_n;
    logic [AW-1:0] addr;
    logic [17:0] data;
  } op_t;

  typedef struct {
    int          due;
    logic [1:0]  vld;
    logic [17:0] word;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic l_ce_lo_n = 1, l_ce_hi = 0, l_rd_wr_n = 1, l_oe_n = 0;
  logic r_ce_lo_n = 1, r_ce_hi = 0, r_rd_wr_n = 1, r_oe_n = 0;
  logic [1:0]  l_bsel_n = 2'b11, r_bsel_n = 2'b11;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [17:0] l_wdata = '0, r_wdata = '0;
  logic [17:0] l_rdata, r_rdata;
  logic [1:0]  l_rvld, r_rvld;

  int checks = 0, fails = 0, cyc = 0;
  bit monitor_on = 0;
  logic [17:0] model [int];
  exp_t lq[$], rq[$];
  logic [17:0] l_last, r_last;
  bit l_have = 0, r_have = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpr_bytelane_ram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_lo_n(l_ce_lo_n), .l_ce_hi(l_ce_hi), .l_rd_wr_n(l_rd_wr_n),
    .l_bsel_n(l_bsel_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvld(l_rvld),
    .r_ce_lo_n(r_ce_lo_n), .r_ce_hi(r_ce_hi), .r_rd_wr_n(r_rd_wr_n),
    .r_bsel_n(r_bsel_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvld(r_rvld)
  );

  function automatic op_t rd(input logic [AW-1:0] a, input logic [1:0] b);
    rd = '{1'b0, 1'b1, 1'b1, b, a, 18'h0};
  endfunction
  function automatic op_t wr(input logic [AW-1:0] a, input logic [1:0] b,
                             input logic [17:0] d);
    wr = '{1'b0, 1'b1, 1'b0, b, a, d};
  endfunction
  function automatic op_t idle();
    idle = '{1'b1, 1'b0, 1'b1, 2'b11, '0, 18'h0};
  endfunction

  function automatic logic [17:0] merge(input logic [17:0] old,
                                        input logic [1:0] lanes,
                                        input logic [17:0] d);
    merge = old;
    if (lanes[0]) merge[8:0]  = d[8:0];
    if (lanes[1]) merge[17:9] = d[17:9];
  endfunction

  function automatic logic [17:0] peek(input int a);
    peek = model.exists(a) ? model[a] : 18'h0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one call per cycle for both ports
  task automatic step(input op_t lo, input op_t ro, input string tag);
    logic sl, sr;
    logic [1:0] ll, rl;
    exp_t el, er;
    @(negedge clk);
    l_ce_lo_n = lo.ce_lo_n; l_ce_hi = lo.ce_hi; l_rd_wr_n = lo.rd;
    l_bsel_n = lo.bsel_n; l_addr = lo.addr; l_wdata = lo.data;
    r_ce_lo_n = ro.ce_lo_n; r_ce_hi = ro.ce_hi; r_rd_wr_n = ro.rd;
    r_bsel_n = ro.bsel_n; r_addr = ro.addr; r_wdata = ro.data;
    sl = !lo.ce_lo_n && lo.ce_hi;
    sr = !ro.ce_lo_n && ro.ce_hi;
    ll = sl ? ~lo.bsel_n : 2'b00;
    rl = sr ? ~ro.bsel_n : 2'b00;
    el.due = cyc + 2; el.tag = tag;
    el.vld = lo.rd ? ll : 2'b00;
    el.word = peek(int'(lo.addr));
    er.due = cyc + 2; er.tag = tag;
    er.vld = ro.rd ? rl : 2'b00;
    er.word = peek(int'(ro.addr));
    lq.push_back(el);
    rq.push_back(er);
    // reads above see old data; apply writes, right last so it wins
    if (!lo.rd && ll != 0) model[int'(lo.addr)] = merge(peek(int'(lo.addr)), ll, lo.data);
    if (!ro.rd && rl != 0) model[int'(ro.addr)] = merge(peek(int'(ro.addr)), rl, ro.data);
  endtask

  task automatic judge(inout exp_t q[$], input logic [17:0] dout,
                       input logic [1:0] vld, input logic oe_n,
                       inout logic [17:0] last, inout bit have,
                       input string side);
    exp_t e;
    if (q.size() == 0 || q[0].due != cyc) return;
    e = q.pop_front();
    check({e.tag, " R6"}, {side, " valid"}, {16'h0, vld},
          {16'h0, e.vld & ~{2{oe_n}}});
    if (e.vld != 0) begin
      check({e.tag, " R5"}, {side, " data"}, dout, e.word);
      last = e.word; have = 1;
    end else if (have) begin
      check({e.tag, " R12"}, {side, " held data"}, dout, last);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (monitor_on) begin
        judge(lq, l_rdata, l_rvld, l_oe_n, l_last, l_have, "left");
        judge(rq, r_rdata, r_rvld, r_oe_n, r_last, r_have, "right");
      end
    end
  end

  // watchdog
  initial begin
    #(5 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11: flags low after reset
    check("R11", "left valid after reset", {16'h0, l_rvld}, 18'h0);
    check("R11", "right valid after reset", {16'h0, r_rvld}, 18'h0);
    monitor_on = 1;

    // R8: fill both regions at once
    for (int i = 0; i < 8; i++)
      step(wr(AW'(i), 2'b00, 18'h1000 + 18'(i * 37)),
           wr(AW'(100 + i), 2'b00, 18'h2A00 + 18'(i * 11)), "R8");
    // R8: cross reads, same address from both in one cycle
    for (int i = 0; i < 8; i++)
      step(rd(AW'(100 + i), 2'b00), rd(AW'(i), 2'b00), "R8");
    step(rd(AW'(3), 2'b00), rd(AW'(3), 2'b00), "R8");

    // R3: single-lane writes, then full reads
    step(wr(AW'(0), 2'b01, 18'h3FFFF), wr(AW'(101), 2'b10, 18'h3FFFF), "R3");
    step(rd(AW'(0), 2'b00), rd(AW'(101), 2'b00), "R3");

    // R4: both lanes disabled, write and read
    step(wr(AW'(1), 2'b11, 18'h15555), rd(AW'(1), 2'b11), "R4");
    step(rd(AW'(1), 2'b00), idle(), "R4");

    // R1: wrong chip-enable combinations
    step('{1'b1, 1'b1, 1'b0, 2'b00, AW'(2), 18'h0AAAA},
         '{1'b0, 1'b0, 1'b0, 2'b00, AW'(102), 18'h0AAAA}, "R1");
    step('{1'b1, 1'b0, 1'b1, 2'b00, AW'(2), 18'h0},
         '{1'b0, 1'b0, 1'b1, 2'b00, AW'(102), 18'h0}, "R1");
    step(rd(AW'(2), 2'b00), rd(AW'(102), 2'b00), "R1");

    // R6: partial-lane reads
    step(rd(AW'(4), 2'b10), rd(AW'(104), 2'b01), "R6");
    step(rd(AW'(5), 2'b01), rd(AW'(105), 2'b10), "R6");

    // R2: write cycles give no valid
    step(wr(AW'(6), 2'b00, 18'h00123), wr(AW'(106), 2'b00, 18'h00456), "R2");
    step(rd(AW'(6), 2'b00), rd(AW'(106), 2'b00), "R2");

    // R9: same-word writes, overlapping and disjoint lanes
    step(wr(AW'(7), 2'b00, 18'h11111), wr(AW'(7), 2'b00, 18'h22222), "R9");
    step(wr(AW'(5), 2'b00, 18'h3C0F0), wr(AW'(5), 2'b01, 18'h0BEEF), "R9");
    step(rd(AW'(7), 2'b00), rd(AW'(5), 2'b00), "R9");

    // R10: read racing the other port's write
    step(rd(AW'(107), 2'b00), wr(AW'(107), 2'b00, 18'h19999), "R10");
    step(wr(AW'(4), 2'b00, 18'h06666), rd(AW'(4), 2'b00), "R10");
    step(rd(AW'(107), 2'b00), rd(AW'(4), 2'b00), "R10");

    // R7: output enable masks flags, data still present
    step(rd(AW'(3), 2'b00), rd(AW'(103), 2'b00), "R7");
    step(idle(), idle(), "R7");
    @(negedge clk);
    l_oe_n = 1; r_oe_n = 1;
    #1;
    check("R7", "left valid gated", {16'h0, l_rvld}, 18'h0);
    check("R7", "right valid gated", {16'h0, r_rvld}, 18'h0);
    step(rd(AW'(0), 2'b00), rd(AW'(100), 2'b00), "R7");
    step(idle(), idle(), "R7");
    step(idle(), idle(), "R7");
    l_oe_n = 0; r_oe_n = 0;

    // R12: idle cycles keep read data
    step(rd(AW'(6), 2'b00), idle(), "R12");
    for (int i = 0; i < 4; i++) step(idle(), wr(AW'(6), 2'b00, 18'h0), "R12");
    step(rd(AW'(6), 2'b00), rd(AW'(6), 2'b00), "R12");
    for (int i = 0; i < 4; i++) step(idle(), idle(), "R12");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule